// File: doc/BRIEF.md
# Parity-Protected Handshake Controller with Mirrored Output Logic

This block is a four-state request/acknowledge controller whose state register and output decoding are checked while it runs. The state code keeps its binary values and gains one extra bit in the top position. That bit is set so that the whole stored word always holds an odd number of ones. The output decoder is built twice. The first copy drives the functional outputs. The second copy exists only so that an equality checker can compare the two copies bit by bit. The next-state logic is built once.

Every check is expressed as a two-rail pair, meaning two wires that must differ from each other. These checks are the state-parity pair, one pair for each output bit, and any number of error pairs coming in from other checked controllers. A tree of two-rail checker cells folds all of them into one global pair. While that pair is complementary (01 or 10), no error has been seen. When it reads 00 or 11, an error is flagged. A system places one such controller per protected sequence and chains the global pairs of upstream controllers into the external inputs of the next controller.

Top module: `hpf_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller is in IDLE: `state_o` reads 3'b100, and `busy_o`, `req_o`, `done_o` and `grant_o` are all 0.
- R2: `state_o[1:0]` holds the state code, with IDLE=2'b00, ISSUE=2'b01, WAIT=2'b10 and DONE=2'b11. `state_o[2]` is a parity bit chosen so that `state_o` always has odd parity.
- R3: From IDLE, the controller moves to ISSUE on a clock edge where `start_i` is 1. Otherwise it stays in IDLE.
- R4: From ISSUE, the controller moves to IDLE if `abort_i` is 1, and to WAIT otherwise.
- R5: From WAIT, `abort_i`=1 returns the controller to IDLE, and this takes priority over `ack_i`. Otherwise `ack_i`=1 moves it to DONE. Otherwise it stays in WAIT.
- R6: From DONE, the controller always returns to IDLE on the next edge.
- R7: The outputs depend combinationally on the current state and inputs: `busy_o` = state not IDLE, `req_o` = state is ISSUE, `done_o` = state is DONE, and `grant_o` = state is WAIT and `ack_i` is 1 and `abort_i` is 0.
- R8: When every external pair (`ext_err0_i[i]`, `ext_err1_i[i]`) is complementary, the global pair is complementary. In that case `err1_o` equals the XOR of `state_o[1]`, `state_o[0]`, all four functional outputs and all bits of `ext_err1_i`.
- R9: When any external pair reads 00 or 11, `err0_o` equals `err1_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction from IDLE |
| ack_i | input | 1 | Acknowledge while waiting |
| abort_i | input | 1 | Cancel from ISSUE or WAIT |
| ext_err0_i | input | N_EXT | Rail 0 of the incoming error pairs |
| ext_err1_i | input | N_EXT | Rail 1 of the incoming error pairs |
| state_o | output | 3 | {parity, state code} |
| busy_o | output | 1 | Controller not idle |
| req_o | output | 1 | Request issued this cycle |
| done_o | output | 1 | Transaction completed |
| grant_o | output | 1 | Acknowledge accepted in WAIT |
| err0_o | output | 1 | Rail 0 of the global error pair |
| err1_o | output | 1 | Rail 1 of the global error pair |

## Verification
Directed sequences walk every edge of the state graph, including abort taken from ISSUE, abort raised together with ack in WAIT, and a long wait with no ack. These show that abort wins over ack and that each transition exists. A long random phase then mixes the control inputs with mostly valid external pairs. The exact value predicted for `err1_o` separates a correct merge tree from one that drops or inverts a rail. Single corrupted external pairs, both 00 and 11 and placed at different indices, confirm that one bad input anywhere collapses the global pair.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
   localparam int unsigned CODE_W = 2;
   localparam int unsigned OUT_W  = 4;

   typedef enum logic [CODE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_ISSUE = 2'b01,
      ST_WAIT  = 2'b10,
      ST_DONE  = 2'b11
   } st_e;

   typedef struct packed {
      logic busy;
      logic req;
      logic done;
      logic grant;
   } ctl_out_t;
endpackage

// File: rtl/hpf_next.sv
module hpf_next
   import hpf_pkg::*;
(
   input  st_e  cur_i,
   input  logic start_i,
   input  logic ack_i,
   input  logic abort_i,
   output st_e  nxt_o
);
   always_comb begin
      nxt_o = cur_i;
      unique case (cur_i)
         ST_IDLE:  if (start_i) nxt_o = ST_ISSUE;
         ST_ISSUE: nxt_o = abort_i ? ST_IDLE : ST_WAIT;
         ST_WAIT: begin
            if (abort_i)    nxt_o = ST_IDLE;
            else if (ack_i) nxt_o = ST_DONE;
         end
         ST_DONE:  nxt_o = ST_IDLE;
         default:  nxt_o = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/hpf_out.sv
module hpf_out
   import hpf_pkg::*;
(
   input  st_e      cur_i,
   input  logic     ack_i,
   input  logic     abort_i,
   output ctl_out_t y_o
);
   always_comb begin
      y_o.busy  = (cur_i != ST_IDLE);
      y_o.req   = (cur_i == ST_ISSUE);
      y_o.done  = (cur_i == ST_DONE);
      y_o.grant = (cur_i == ST_WAIT) && ack_i && !abort_i;
   end
endmodule

// File: rtl/trc_cell.sv
module trc_cell (
   input  logic a0_i,
   input  logic a1_i,
   input  logic b0_i,
   input  logic b1_i,
   output logic z0_o,
   output logic z1_o
);
   assign z0_o = (a0_i & b0_i) | (a1_i & b1_i);
   assign z1_o = (a0_i & b1_i) | (a1_i & b0_i);
endmodule

// File: rtl/trc_tree.sv
module trc_tree #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] in0_i,
   input  logic [N-1:0] in1_i,
   output logic         z0_o,
   output logic         z1_o
);
   localparam int unsigned NODES = 2*N - 1;

   logic [NODES-1:0] n0, n1;

   if (N < 1) begin : g_bad_n
      $error("trc_tree: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_leaf
      assign n0[N-1+i] = in0_i[i];
      assign n1[N-1+i] = in1_i[i];
   end

   for (genvar k = 0; k + 1 < N; k++) begin : g_node
      trc_cell u_cell (
         .a0_i (n0[2*k+1]),
         .a1_i (n1[2*k+1]),
         .b0_i (n0[2*k+2]),
         .b1_i (n1[2*k+2]),
         .z0_o (n0[k]),
         .z1_o (n1[k])
      );
   end

   assign z0_o = n0[0];
   assign z1_o = n1[0];
endmodule

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
   import hpf_pkg::*;
#(
   parameter int unsigned N_EXT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ack_i,
   input  logic             abort_i,
   input  logic [N_EXT-1:0] ext_err0_i,
   input  logic [N_EXT-1:0] ext_err1_i,
   output logic [CODE_W:0]  state_o,
   output logic             busy_o,
   output logic             req_o,
   output logic             done_o,
   output logic             grant_o,
   output logic             err0_o,
   output logic             err1_o
);
   localparam int unsigned NPAIR = 1 + OUT_W + N_EXT;

   if (N_EXT < 1) begin : g_bad_ext
      $error("hpf_ctrl: N_EXT must be at least 1");
   end

   logic [CODE_W:0] st_q;
   st_e             cur, nxt;
   ctl_out_t        y_copy [2];
   logic [OUT_W-1:0] y_a, y_b;

   assign cur = st_e'(st_q[CODE_W-1:0]);

   hpf_next u_next (
      .cur_i   (cur),
      .start_i (start_i),
      .ack_i   (ack_i),
      .abort_i (abort_i),
      .nxt_o   (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {1'b1, ST_IDLE};
      else        st_q <= {~^nxt, nxt};
   end

   for (genvar c = 0; c < 2; c++) begin : g_dup
      hpf_out u_out (
         .cur_i   (cur),
         .ack_i   (ack_i),
         .abort_i (abort_i),
         .y_o     (y_copy[c])
      );
   end

   assign y_a = y_copy[0];
   assign y_b = y_copy[1];

   logic [NPAIR-1:0] pr0, pr1;
   assign pr0 = {ext_err0_i, y_a,  st_q[CODE_W]};
   assign pr1 = {ext_err1_i, ~y_b, ^st_q[CODE_W-1:0]};

   trc_tree #(.N(NPAIR)) u_tree (
      .in0_i (pr0),
      .in1_i (pr1),
      .z0_o  (err0_o),
      .z1_o  (err1_o)
   );

   assign state_o = st_q;
   assign busy_o  = y_copy[0].busy;
   assign req_o   = y_copy[0].req;
   assign done_o  = y_copy[0].done;
   assign grant_o = y_copy[0].grant;
endmodule

// File: rtl/hpf_ctrl_chk.sv
module hpf_ctrl_chk #(
   parameter int unsigned N_EXT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_i,
   input logic             abort_i,
   input logic [N_EXT-1:0] ext_err0_i,
   input logic [N_EXT-1:0] ext_err1_i,
   input logic [2:0]       state_o,
   input logic             req_o,
   input logic             done_o,
   input logic             err0_o,
   input logic             err1_o
);
   a_r2_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
      ^state_o == 1'b1);

   a_r6_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[1:0] == 2'b11 |=> state_o[1:0] == 2'b00);

   a_r5_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o[1:0] == 2'b10 && abort_i && ack_i) |=> state_o[1:0] == 2'b00);

   a_r7_req_in_issue: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> state_o[1:0] == 2'b01);

   a_r7_done_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> state_o[1:0] == 2'b11);

   a_r8_clean_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (&(ext_err0_i ^ ext_err1_i)) |-> (err0_o != err1_o));

   a_r9_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !(&(ext_err0_i ^ ext_err1_i)) |-> (err0_o == err1_o));
endmodule

bind hpf_ctrl hpf_ctrl_chk #(.N_EXT(N_EXT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack_i      (ack_i),
   .abort_i    (abort_i),
   .ext_err0_i (ext_err0_i),
   .ext_err1_i (ext_err1_i),
   .state_o    (state_o),
   .req_o      (req_o),
   .done_o     (done_o),
   .err0_o     (err0_o),
   .err1_o     (err1_o)
);

// File: tb/hpf_ctrl_tb_top.sv
`timescale 1ns/1ps
module hpf_ctrl_tb_top;
   localparam int unsigned NE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, ack_i = 1'b0, abort_i = 1'b0;
   logic [NE-1:0] e0 = '0, e1 = '1;
   logic [2:0] state_o;
   logic busy_o, req_o, done_o, grant_o, err0_o, err1_o;

   int n_chk = 0;
   int n_bad = 0;
   int mst = 0;

   always #2.5 clk = ~clk;

   hpf_ctrl #(.N_EXT(NE)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
      .abort_i(abort_i), .ext_err0_i(e0), .ext_err1_i(e1),
      .state_o(state_o), .busy_o(busy_o), .req_o(req_o), .done_o(done_o),
      .grant_o(grant_o), .err0_o(err0_o), .err1_o(err1_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int nxt_of(int s, bit st, bit ak, bit ab);
      case (s)
         0: return st ? 1 : 0;
         1: return ab ? 0 : 2;
         2: return ab ? 0 : (ak ? 3 : 2);
         default: return 0;
      endcase
   endfunction

   task automatic cyc(input bit st, input bit ak, input bit ab,
                      input logic [NE-1:0] x0, input logic [NE-1:0] x1);
      bit eb, er, ed, eg, par, valid, ex1;
      @(negedge clk);
      start_i = st; ack_i = ak; abort_i = ab; e0 = x0; e1 = x1;
      #1;
      par = ~(mst[1] ^ mst[0]);
      chk("R2 state", int'(state_o), (int'(par) << 2) | mst);
      eb = (mst != 0); er = (mst == 1); ed = (mst == 3);
      eg = (mst == 2) && ak && !ab;
      chk("R7 outputs", {busy_o, req_o, done_o, grant_o}, {eb, er, ed, eg});
      valid = &(x0 ^ x1);
      if (valid) begin
         ex1 = mst[1] ^ mst[0] ^ eb ^ er ^ ed ^ eg ^ (^x1);
         chk("R8 err pair", {err0_o, err1_o}, {~ex1, ex1});
      end else begin
         chk("R9 err collapse", int'(err0_o == err1_o), 1);
      end
      @(posedge clk);
      mst = nxt_of(mst, st, ak, ab);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3;
      chk("R1 reset state", int'(state_o), 4);
      chk("R1 reset outputs", {busy_o, req_o, done_o, grant_o}, 0);
      #10 rst_n = 1'b1;
      // R3 hold in IDLE, then start
      cyc(0, 1, 1, 2'b00, 2'b11);
      cyc(1, 0, 0, 2'b01, 2'b10);
      // R4 issue -> wait, R5 long wait, ack -> done, R6 done -> idle
      cyc(0, 0, 0, 2'b10, 2'b01);
      cyc(0, 0, 0, 2'b00, 2'b11);
      cyc(0, 0, 0, 2'b11, 2'b00);
      cyc(0, 1, 0, 2'b01, 2'b10);
      cyc(1, 1, 1, 2'b00, 2'b11);
      // R4 abort from ISSUE
      cyc(1, 0, 0, 2'b00, 2'b11);
      cyc(0, 0, 1, 2'b00, 2'b11);
      // R5 abort and ack together in WAIT
      cyc(1, 0, 0, 2'b00, 2'b11);
      cyc(0, 0, 0, 2'b00, 2'b11);
      cyc(0, 1, 1, 2'b00, 2'b11);
      cyc(0, 0, 0, 2'b00, 2'b11);
      // R9 single bad pair at each index, both 00 and 11
      cyc(1, 0, 0, 2'b00, 2'b01);
      cyc(0, 0, 0, 2'b11, 2'b01);
      cyc(0, 1, 0, 2'b01, 2'b00);
      cyc(0, 0, 0, 2'b01, 2'b11);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [NE-1:0] r0, r1;
         r0 = NE'($urandom);
         r1 = ~r0;
         if ($urandom_range(0, 7) == 0) r1[$urandom_range(0, NE-1)] ^= 1'b1;
         cyc(1'($urandom), 1'($urandom), ($urandom_range(0, 5) == 0), r0, r1);
      end
      // R1 asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 reset state", int'(state_o), 4);
      chk("R1 reset outputs", {busy_o, req_o, done_o}, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule